// File: doc/BRIEF.md
# Burst DMA Command Beat Assembler

This block sits behind one data-register address of a flash controller. Software writes a DMA command there as four 16-bit beats in a fixed order. The beats may come as a single four-beat incrementing burst or as four single writes with gaps between them. When the last beat arrives, the block decodes the page count, the transfer direction, the 32-bit host buffer address, the burst length and the interrupt request. If the command is well formed, the block offers it to a downstream DMA engine over a valid/ready handshake. It then waits until the engine signals that the transfer has ended.

A malformed command is discarded. It raises a one-cycle error pulse and returns the beat count to zero. At the end of a transfer, a sticky completion bit is set if the command asked for an interrupt. That bit drives the interrupt output until software clears it.

The controller is an FSM with three states.

- `ST_COLLECT` accepts beats.
  - Transition *beat_done_ok* leads to `ST_ISSUE`.
  - Transition *beat_done_bad* stays in `ST_COLLECT` and pulses the error.
- `ST_ISSUE` holds `cmd_valid` high.
  - Transition *engine_took* leads to `ST_BUSY`.
- `ST_BUSY` waits for the engine.
  - Transition *engine_finished* returns to `ST_COLLECT`.

Top module: `dma_cmd_assembler`

## Requirements
- R1: After reset, `wr_ready`=1, and `cmd_valid`, `cmd_err`, `done_sts` and `irq` are all 0.
- R2: The beats are written to address `CMD_OFS` (0x10) in this order:
  - beat 0 holds pages [7:0], direction [11:8] (0 = read, 1 = write) and type [15:12], which must be 0x2;
  - beat 1 holds address [31:16];
  - beat 2 holds address [15:0];
  - beat 3 holds burst length [7:0], the interrupt flag [8] and a reserved field [15:9], which must be 0.

  A well-formed command appears on the `cmd_*` outputs, with `cmd_valid`=1, in the cycle after the fourth beat is accepted.
- R3: Back-to-back beats and beats separated by idle cycles produce the same command.
- R4: A write to any address other than `CMD_OFS` is accepted and is not counted as a beat.
- R5: A command is malformed if the type is not 0x2, the direction is above 1, the reserved field is nonzero, or address bits [1:0] are nonzero. A malformed command gives `cmd_err`=1 for exactly the cycle after its fourth beat and never raises `cmd_valid`. The next beat is then treated as beat 0.
- R6: While `cmd_valid`=1 and `cmd_ready`=0, `cmd_valid` and all command fields stay unchanged.
- R7: `wr_ready`=0 from the cycle after a well-formed fourth beat until the cycle after `eng_done` is seen in `ST_BUSY`. A write stalled during that time is accepted later and is not lost.
- R8: On `eng_done` in `ST_BUSY`, `done_sts` becomes 1 in the next cycle if the command's interrupt flag was 1. If the flag was 0, `done_sts` is left unchanged. `irq` always equals `done_sts`.
- R9: `done_sts` stays at 1 until `sts_clr`=1. If a set and a clear happen in the same cycle, the set wins.
- R10: `eng_done` outside `ST_BUSY` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write strobe |
| wr_ready | output | 1 | Write accepted this cycle when high |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 16 | Register write data (one beat) |
| cmd_valid | output | 1 | Decoded command offered to engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_pages | output | 8 | Number of pages |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | 32 | Host buffer address |
| cmd_burst | output | 8 | Burst length |
| cmd_irq | output | 1 | Interrupt requested at completion |
| eng_done | input | 1 | Engine reports end of transfer |
| cmd_err | output | 1 | One-cycle pulse for a malformed command |
| sts_clr | input | 1 | Write-1 clear of the completion bit |
| done_sts | output | 1 | Sticky completion status |
| irq | output | 1 | Interrupt output |

## Verification
Timing of each result, counted from the clock edge that applies the stimulus:

| Stimulus edge | Result | Due |
|---|---|---|
| Fourth beat accepted | `cmd_valid` and the fields, or the error pulse | One cycle later |
| Fourth beat accepted (well formed) | `wr_ready` falls | One cycle later |
| `eng_done` in `ST_BUSY` | `done_sts` rises | One cycle later |
| `eng_done` in `ST_BUSY` | `wr_ready` returns | One cycle later |
| `sts_clr` | `done_sts` clears | One cycle later |

The bench updates a behavioural model at each rising edge from the inputs it drove. It compares every output against that model at the following falling edge, so each comparison falls in the cycle in which its result is due. Fixed-value checks on known commands confirm the field positions independently of the model.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;

    localparam int BEAT_W  = 16;
    localparam int N_BEATS = 4;
    localparam logic [3:0] CMD_TYPE = 4'h2;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_ISSUE   = 2'd1,
        ST_BUSY    = 2'd2
    } asm_state_e;

    typedef struct packed {
        logic [7:0]  pages;
        logic        is_write;
        logic [31:0] addr;
        logic [7:0]  burst;
        logic        want_irq;
    } dma_cmd_t;

endpackage

// File: rtl/dma_beat_collect.sv
module dma_beat_collect
    import dma_cmd_pkg::*;
#(
    parameter int BEATS = N_BEATS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         take,
    input  logic [BEAT_W-1:0]            beat_in,
    output logic                         at_last,
    output logic [BEATS-2:0][BEAT_W-1:0] held
);
    localparam int CNT_W = $clog2(BEATS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEATS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign at_last = (cnt_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

    for (genvar g = 0; g < BEATS - 1; g++) begin : g_hold
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held[g] <= '0;
            end else if (take && cnt_q == CNT_W'(g)) begin
                held[g] <= beat_in;
            end
        end
    end

    // R5: after the final beat the count restarts at beat 0
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && at_last) |=> (cnt_q == '0));

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !at_last) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(cnt_q));

endmodule

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
    import dma_cmd_pkg::*;
(
    input  logic [N_BEATS-1:0][BEAT_W-1:0] beats,
    output dma_cmd_t                       cmd,
    output logic                           bad
);
    logic [3:0] type_f;
    logic [3:0] dir_f;
    logic [6:0] rsvd_f;

    always_comb begin
        type_f       = beats[0][15:12];
        dir_f        = beats[0][11:8];
        rsvd_f       = beats[3][15:9];
        cmd.pages    = beats[0][7:0];
        cmd.is_write = dir_f[0];
        cmd.addr     = {beats[1], beats[2]};
        cmd.burst    = beats[3][7:0];
        cmd.want_irq = beats[3][8];
        bad = (type_f != CMD_TYPE) || (dir_f > 4'd1) ||
              (rsvd_f != '0) || (cmd.addr[1:0] != 2'b00);
    end

endmodule

// File: rtl/dma_done_status.sv
module dma_done_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic done_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (set) begin
            done_q <= 1'b1;
        end else if (clr) begin
            done_q <= 1'b0;
        end
    end

    p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> done_q);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !clr) |=> done_q);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !done_q);

endmodule

// File: rtl/dma_cmd_assembler.sv
module dma_cmd_assembler
    import dma_cmd_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter logic [7:0]  CMD_OFS = 8'h10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    output logic                 wr_ready,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BEAT_W-1:0]    wr_data,
    output logic                 cmd_valid,
    input  logic                 cmd_ready,
    output logic [7:0]           cmd_pages,
    output logic                 cmd_write,
    output logic [31:0]          cmd_addr,
    output logic [7:0]           cmd_burst,
    output logic                 cmd_irq,
    input  logic                 eng_done,
    output logic                 cmd_err,
    input  logic                 sts_clr,
    output logic                 done_sts,
    output logic                 irq
);
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(CMD_OFS);

    asm_state_e state_q, state_d;
    dma_cmd_t   cmd_q, dec_cmd;
    logic       dec_bad, at_last, beat_take, beats_done, err_q, done_set;
    logic [N_BEATS-2:0][BEAT_W-1:0] held;
    logic [N_BEATS-1:0][BEAT_W-1:0] all_beats;

    assign beat_take  = wr_valid && wr_ready && (wr_addr == OFS);
    assign beats_done = beat_take && at_last;

    dma_beat_collect #(.BEATS(N_BEATS)) u_collect (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (beat_take),
        .beat_in (wr_data),
        .at_last (at_last),
        .held    (held)
    );

    always_comb begin
        all_beats = {wr_data, held};
    end

    dma_cmd_decode u_decode (
        .beats (all_beats),
        .cmd   (dec_cmd),
        .bad   (dec_bad)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_COLLECT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT: if (beats_done && !dec_bad) state_d = ST_ISSUE;  // beat_done_ok
            ST_ISSUE:   if (cmd_ready)              state_d = ST_BUSY;   // engine_took
            ST_BUSY:    if (eng_done)               state_d = ST_COLLECT; // engine_finished
            default:                                state_d = ST_COLLECT;
        endcase
    end

    // outputs
    always_comb begin
        wr_ready  = 1'b0;
        cmd_valid = 1'b0;
        done_set  = 1'b0;
        unique case (state_q)
            ST_COLLECT: wr_ready  = 1'b1;
            ST_ISSUE:   cmd_valid = 1'b1;
            ST_BUSY:    done_set  = eng_done && cmd_q.want_irq;
            default:    wr_ready  = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= beats_done && dec_bad;  // beat_done_bad
            if (beats_done && !dec_bad) cmd_q <= dec_cmd;
        end
    end

    dma_done_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (done_set),
        .clr    (sts_clr),
        .done_q (done_sts)
    );

    assign cmd_pages = cmd_q.pages;
    assign cmd_write = cmd_q.is_write;
    assign cmd_addr  = cmd_q.addr;
    assign cmd_burst = cmd_q.burst;
    assign cmd_irq   = cmd_q.want_irq;
    assign cmd_err   = err_q;
    assign irq       = done_sts;

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
            $stable(cmd_pages) && $stable(cmd_burst) && $stable(cmd_write) && $stable(cmd_irq)));

    p_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_addr[1:0] == 2'b00));

    p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> !cmd_err);

    p_err_no_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (!cmd_valid && wr_ready));

    p_issue_after_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> $past(wr_valid && (wr_addr == OFS)));

    p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || (!wr_ready && !$past(eng_done))) |=> !wr_ready || $past(eng_done));

    p_idle_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && !sts_clr) |=> (done_sts == $past(done_sts)));

endmodule

// File: tb/dma_cmd_assembler_tb.sv
module dma_cmd_assembler_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        cmd_ready = 1'b0;
    logic        eng_done = 1'b0;
    logic        sts_clr = 1'b0;
    logic        wr_ready, cmd_valid, cmd_write, cmd_irq, cmd_err, done_sts, irq;
    logic [7:0]  cmd_pages, cmd_burst;
    logic [31:0] cmd_addr;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;  // 125 MHz

    dma_cmd_assembler dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_pages(cmd_pages), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_burst(cmd_burst), .cmd_irq(cmd_irq),
        .eng_done(eng_done), .cmd_err(cmd_err), .sts_clr(sts_clr),
        .done_sts(done_sts), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    int          m_state = 0;   // 0 collect, 1 issue, 2 busy
    logic [15:0] m_q[$];
    logic        m_err = 0;
    logic        m_done = 0;
    logic [7:0]  m_pages = 0, m_burst = 0;
    logic [31:0] m_addr = 0;
    logic        m_wr = 0, m_irqf = 0;
    int          m_errs_seen = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_q.delete(); m_err = 0; m_done = 0;
            m_pages = 0; m_burst = 0; m_addr = 0; m_wr = 0; m_irqf = 0;
        end else begin
            logic setd;
            setd = 0;
            m_err = 0;
            if (m_state == 0) begin
                if (wr_valid && wr_addr == 8'h10) begin
                    m_q.push_back(wr_data);
                    if (m_q.size() == 4) begin
                        logic [31:0] a;
                        a = {m_q[1], m_q[2]};
                        if (m_q[0][15:12] != 4'h2 || m_q[0][11:8] > 4'h1 ||
                            m_q[3][15:9] != 0 || a[1:0] != 0) begin
                            m_err = 1; m_errs_seen++;
                        end else begin
                            m_pages = m_q[0][7:0]; m_wr = m_q[0][8];
                            m_addr = a; m_burst = m_q[3][7:0]; m_irqf = m_q[3][8];
                            m_state = 1;
                        end
                        m_q.delete();
                    end
                end
            end else if (m_state == 1) begin
                if (cmd_ready) m_state = 2;
            end else begin
                if (eng_done) begin
                    m_state = 0;
                    setd = m_irqf;
                end
            end
            if (setd) m_done = 1;
            else if (sts_clr) m_done = 0;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R7 wr_ready", 32'(wr_ready), 32'(m_state == 0));
            chk("R2 cmd_valid", 32'(cmd_valid), 32'(m_state == 1));
            if (m_state == 1) begin
                chk("R6 cmd_addr", cmd_addr, m_addr);
                chk("R2 cmd_pages", 32'(cmd_pages), 32'(m_pages));
                chk("R2 cmd_write", 32'(cmd_write), 32'(m_wr));
                chk("R2 cmd_burst", 32'(cmd_burst), 32'(m_burst));
                chk("R2 cmd_irq", 32'(cmd_irq), 32'(m_irqf));
            end
            chk("R5 cmd_err", 32'(cmd_err), 32'(m_err));
            chk("R8 done_sts", 32'(done_sts), 32'(m_done));
            chk("R8 irq", 32'(irq), 32'(m_done));
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic put(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        wr_valid = 1; wr_addr = a; wr_data = d;
        while (!wr_ready) @(negedge clk);
        @(posedge clk);
        #1 wr_valid = 0;
    endtask

    task automatic send_cmd(logic [15:0] b0, b1, b2, b3, int gap);
        put(8'h10, b0); repeat (gap) @(negedge clk);
        put(8'h10, b1); repeat (gap) @(negedge clk);
        put(8'h10, b2); repeat (gap) @(negedge clk);
        put(8'h10, b3);
    endtask

    task automatic engine(int rdy_dly, int done_dly, bit clr_too);
        @(negedge clk);
        while (!cmd_valid) @(negedge clk);
        repeat (rdy_dly) @(negedge clk);
        cmd_ready = 1;
        @(negedge clk); cmd_ready = 0;
        repeat (done_dly) @(negedge clk);
        eng_done = 1; sts_clr = clr_too;
        @(negedge clk); eng_done = 0; sts_clr = 0;
    endtask

    initial begin
        int e0;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 wr_ready", 32'(wr_ready), 32'd1);
        chk("R1 cmd_valid", 32'(cmd_valid), 32'd0);
        chk("R1 done_sts", 32'(done_sts), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 cmd_err", 32'(cmd_err), 32'd0);
        rst_n = 1;
        @(negedge clk);

        // R2 R3: back-to-back burst, write, irq set
        send_cmd(16'h2105, 16'h1234, 16'h5678, 16'h0140, 0);
        @(negedge clk);
        chk("R2 valid next cycle", 32'(cmd_valid), 32'd1);
        chk("R2 addr", cmd_addr, 32'h1234_5678);
        chk("R2 pages", 32'(cmd_pages), 32'd5);
        chk("R2 write", 32'(cmd_write), 32'd1);
        chk("R2 burst", 32'(cmd_burst), 32'h40);
        chk("R2 irq flag", 32'(cmd_irq), 32'd1);
        engine(3, 2, 0);   // R6 hold for 3 cycles
        chk("R8 done set", 32'(done_sts), 32'd1);
        chk("R8 irq out", 32'(irq), 32'd1);

        // R9 clear
        @(negedge clk); sts_clr = 1; @(negedge clk); sts_clr = 0;
        chk("R9 cleared", 32'(done_sts), 32'd0);

        // R3 R4: gapped beats with a foreign-address write inside, read, no irq
        put(8'h10, 16'h2003);
        put(8'h14, 16'hFFFF);
        repeat (2) @(negedge clk);
        put(8'h10, 16'h0000);
        put(8'h10, 16'h0100);
        repeat (3) @(negedge clk);
        put(8'h10, 16'h0010);
        @(negedge clk);
        chk("R4 foreign ignored addr", cmd_addr, 32'h0000_0100);
        chk("R3 gapped pages", 32'(cmd_pages), 32'd3);
        chk("R3 gapped read", 32'(cmd_write), 32'd0);
        engine(0, 1, 0);
        chk("R8 no irq leaves done", 32'(done_sts), 32'd0);

        // R5 malformed forms
        e0 = m_errs_seen;
        send_cmd(16'h3101, 16'h0000, 16'h0040, 16'h0001, 0);  // bad type
        @(negedge clk);
        chk("R5 err type", 32'(cmd_err), 32'd1);
        send_cmd(16'h2201, 16'h0000, 16'h0040, 16'h0001, 1);  // bad dir
        send_cmd(16'h2101, 16'h0000, 16'h0040, 16'h0201, 0);  // reserved
        send_cmd(16'h2101, 16'h0000, 16'h0042, 16'h0001, 0);  // misaligned
        @(negedge clk);
        chk("R5 error count", 32'(m_errs_seen - e0), 32'd4);
        chk("R5 no issue", 32'(cmd_valid), 32'd0);
        // R5 counter reset: a good command right after
        send_cmd(16'h2107, 16'hABCD, 16'h0008, 16'h0120, 0);
        @(negedge clk);
        chk("R5 restart addr", cmd_addr, 32'hABCD_0008);

        // R7 stall: next command's beats arrive while busy
        fork
            send_cmd(16'h2002, 16'h0001, 16'h0004, 16'h0102, 0);
            engine(4, 3, 0);
        join
        @(negedge clk);
        chk("R7 stalled beats kept", cmd_addr, 32'h0001_0004);
        chk("R7 stalled pages", 32'(cmd_pages), 32'd2);

        // R9 set wins over clear in same cycle (current cmd has irq)
        @(negedge clk); sts_clr = 1; @(negedge clk); sts_clr = 0;
        engine(1, 1, 1);
        chk("R9 set beats clear", 32'(done_sts), 32'd1);

        // R10 eng_done while collecting
        @(negedge clk); sts_clr = 1; @(negedge clk); sts_clr = 0;
        send_cmd(16'h2101, 16'h0000, 16'h0010, 16'h0101, 0);
        @(negedge clk); cmd_ready = 1; @(negedge clk); cmd_ready = 0;
        eng_done = 1; @(negedge clk); eng_done = 0;
        @(negedge clk);
        eng_done = 1; @(negedge clk); eng_done = 0;
        @(negedge clk);
        chk("R10 idle done ignored", 32'(done_sts), 32'd1);
        @(negedge clk); sts_clr = 1; @(negedge clk); sts_clr = 0;
        eng_done = 1; @(negedge clk); eng_done = 0;
        @(negedge clk);
        chk("R10 no set in collect", 32'(done_sts), 32'd0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule